// File: doc/BRIEF.md
# GPIO Port with Per-Pin Event Detection

This block is a 32-pin general-purpose I/O port. A small register interface reaches two spaces. The data space holds the output data, the direction bits and a readback of the synchronized pin inputs. The event space holds one control word per pin and a shared flag register. Each pin's control word selects how that pin is watched. It can be idle, raise a DMA request on an edge, or raise an interrupt on an edge or on a level.

A detected event latches a per-pin flag. The flags of pins in interrupt modes are ORed into one interrupt line for the whole port. The flags of pins in DMA modes are ORed into a DMA request line. Software clears a flag by writing a one, either to the shared flag register or to bit 24 of the pin's own control word. An acknowledge pulse from the DMA engine clears every flag that belongs to a DMA-mode pin.

Top module: `gpio_evt_port`

## Requirements
- R1: After reset, the output data, the direction bits, every mode field and every flag read as zero, and `irq_o` and `dma_req_o` are low.
- R2: In the data space (`space_i`=0), a write to 0x00 sets the output data and a write to 0x14 sets the direction bits. Both read back and appear on `pin_o` and `pin_oe_o`; a direction bit of 1 enables the output.
- R3: Reading data-space offset 0x10 returns `pin_i` through two flops. A change made after clock edge E0 reads back only after edge E2.
- R4: The interrupt edge modes are 0x9 (rising), 0xA (falling) and 0xB (either edge). Each sets the pin's flag only on its own edge direction of the synchronized input and drives `irq_o`. The flag is set at the third clock edge after `pin_i` changes.
- R5: The level modes are 0x8 (low) and 0xC (high). They set the flag while the synchronized input is at that level, so a clear made while the level persists leaves the flag set.
- R6: The DMA modes are 0x1 (rising), 0x2 (falling) and 0x3 (either edge). Their flags drive `dma_req_o` and not `irq_o`. A one-cycle `dma_ack_i` clears the flags of DMA-mode pins only.
- R7: The flag register is at event-space offset 0xA0, with bit i belonging to pin i. Writing 1 clears that flag, writing 0 leaves it unchanged, and writing all ones clears every flag.
- R8: The control word of pin i is at event-space offset 4*i. Its mode reads back in bits 19:16 and its flag in bit 24, and writing 1 to bit 24 clears that pin's flag.
- R9: Rewriting a pin's mode does not clear its flag. A flag held under a non-interrupt mode does not drive `irq_o`.
- R10: Mode codes other than 0x1-0x3 and 0x8-0xC never set a flag. The stored code still reads back.
- R11: When a clear and a new event hit the same pin in the same cycle, the flag remains set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Register access strobe |
| we_i | input | 1 | Write enable for the access |
| space_i | input | 1 | 0 selects the data space, 1 selects the event space |
| addr_i | input | 8 | Byte offset |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, combinational from the address |
| pin_i | input | 32 | Pin input levels |
| pin_o | output | 32 | Pin output data |
| pin_oe_o | output | 32 | Pin output enables |
| dma_ack_i | input | 1 | DMA acknowledge pulse |
| irq_o | output | 1 | Combined interrupt |
| dma_req_o | output | 1 | Combined DMA request |

## Verification
The detector is driven with single rising and falling transitions in each edge mode. These show that every mode reacts only to its own direction. Level stimuli held across a clear separate level sensing from edge latching. A second rising edge timed to land on the same edge as a clear write shows that the set takes priority. Mixed DMA and interrupt pins acknowledged together show that the acknowledge clears only the DMA flags. Undefined codes toggled both ways confirm that they stay inert.

// File: rtl/gpio_evt_pkg.sv
package gpio_evt_pkg;
  typedef enum logic [3:0] {
    MD_OFF      = 4'h0,
    MD_DMA_RISE = 4'h1,
    MD_DMA_FALL = 4'h2,
    MD_DMA_BOTH = 4'h3,
    MD_IRQ_LOW  = 4'h8,
    MD_IRQ_RISE = 4'h9,
    MD_IRQ_FALL = 4'hA,
    MD_IRQ_BOTH = 4'hB,
    MD_IRQ_HIGH = 4'hC
  } evt_mode_e;

  localparam int MODE_LSB  = 16;
  localparam int MODE_W    = 4;
  localparam int FLAG_BIT  = 24;
  localparam int OFS_DOUT  = 'h00;
  localparam int OFS_PIN   = 'h10;
  localparam int OFS_DIR   = 'h14;
  localparam int OFS_FLAGS = 'hA0;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/gpio_pin_det.sv
module gpio_pin_det
  import gpio_evt_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       in_i,
  input  logic [3:0] mode_i,
  input  logic       clr_i,
  output logic       ev_o,
  output logic       flag_o,
  output logic       irq_sel_o,
  output logic       dma_sel_o
);
  logic prev_q, flag_q, rise, fall;

  assign rise = in_i & ~prev_q;
  assign fall = ~in_i & prev_q;

  always_comb begin
    ev_o      = 1'b0;
    irq_sel_o = 1'b0;
    dma_sel_o = 1'b0;
    case (evt_mode_e'(mode_i))
      MD_DMA_RISE: begin ev_o = rise;        dma_sel_o = 1'b1; end
      MD_DMA_FALL: begin ev_o = fall;        dma_sel_o = 1'b1; end
      MD_DMA_BOTH: begin ev_o = rise | fall; dma_sel_o = 1'b1; end
      MD_IRQ_LOW:  begin ev_o = ~in_i;       irq_sel_o = 1'b1; end
      MD_IRQ_RISE: begin ev_o = rise;        irq_sel_o = 1'b1; end
      MD_IRQ_FALL: begin ev_o = fall;        irq_sel_o = 1'b1; end
      MD_IRQ_BOTH: begin ev_o = rise | fall; irq_sel_o = 1'b1; end
      MD_IRQ_HIGH: begin ev_o = in_i;        irq_sel_o = 1'b1; end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      prev_q <= in_i;
      flag_q <= ev_o | (flag_q & ~clr_i);  // set wins
    end
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/gpio_evt_port.sv
module gpio_evt_port
  import gpio_evt_pkg::*;
#(
  parameter int N_PIN = 32,
  parameter int AW    = 8,
  parameter int DW    = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_i,
  input  logic             we_i,
  input  logic             space_i,
  input  logic [AW-1:0]    addr_i,
  input  logic [DW-1:0]    wdata_i,
  output logic [DW-1:0]    rdata_o,
  input  logic [N_PIN-1:0] pin_i,
  output logic [N_PIN-1:0] pin_o,
  output logic [N_PIN-1:0] pin_oe_o,
  input  logic             dma_ack_i,
  output logic             irq_o,
  output logic             dma_req_o
);
  localparam int IDX_W    = (N_PIN > 1) ? $clog2(N_PIN) : 1;
  localparam int CTRL_END = N_PIN * 4;

  logic [N_PIN-1:0] dout_q, dir_q, pin_s;
  logic [N_PIN-1:0] flag_q, ev_v, clr_v, irq_sel, dma_sel;
  logic [MODE_W-1:0] mode_q [N_PIN];
  logic wr, data_we, evt_we, ctrl_hit, ctrl_we, stat_we;
  logic [IDX_W-1:0] ctrl_idx;

  assign wr       = req_i & we_i;
  assign data_we  = wr & ~space_i;
  assign evt_we   = wr & space_i;
  assign ctrl_hit = (addr_i < AW'(CTRL_END)) && (addr_i[1:0] == 2'b00);
  assign ctrl_idx = addr_i[IDX_W+1:2];
  assign ctrl_we  = evt_we & ctrl_hit;
  assign stat_we  = evt_we & (addr_i == AW'(OFS_FLAGS));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dout_q <= '0;
      dir_q  <= '0;
    end else if (data_we) begin
      if (addr_i == AW'(OFS_DOUT)) dout_q <= wdata_i[N_PIN-1:0];
      if (addr_i == AW'(OFS_DIR))  dir_q  <= wdata_i[N_PIN-1:0];
    end
  end

  gpio_sync #(.W(N_PIN)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pin_i),
    .q_o   (pin_s)
  );

  for (genvar i = 0; i < N_PIN; i++) begin : g_pin
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                mode_q[i] <= '0;
      else if (ctrl_we && ctrl_idx == IDX_W'(i))  mode_q[i] <= wdata_i[MODE_LSB +: MODE_W];
    end

    assign clr_v[i] = (stat_we & wdata_i[i])
                    | (ctrl_we & (ctrl_idx == IDX_W'(i)) & wdata_i[FLAG_BIT])
                    | (dma_ack_i & dma_sel[i]);

    gpio_pin_det u_det (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .in_i     (pin_s[i]),
      .mode_i   (mode_q[i]),
      .clr_i    (clr_v[i]),
      .ev_o     (ev_v[i]),
      .flag_o   (flag_q[i]),
      .irq_sel_o(irq_sel[i]),
      .dma_sel_o(dma_sel[i])
    );
  end

  always_comb begin
    rdata_o = '0;
    if (!space_i) begin
      if (addr_i == AW'(OFS_DOUT)) rdata_o[N_PIN-1:0] = dout_q;
      if (addr_i == AW'(OFS_PIN))  rdata_o[N_PIN-1:0] = pin_s;
      if (addr_i == AW'(OFS_DIR))  rdata_o[N_PIN-1:0] = dir_q;
    end else if (ctrl_hit) begin
      rdata_o[MODE_LSB +: MODE_W] = mode_q[ctrl_idx];
      rdata_o[FLAG_BIT]           = flag_q[ctrl_idx];
    end else if (addr_i == AW'(OFS_FLAGS)) begin
      rdata_o[N_PIN-1:0] = flag_q;
    end
  end

  assign pin_o     = dout_q;
  assign pin_oe_o  = dir_q;
  assign irq_o     = |(flag_q & irq_sel);
  assign dma_req_o = |(flag_q & dma_sel);
endmodule

// File: rtl/gpio_evt_chk.sv
module gpio_evt_chk #(
  parameter int N_PIN = 32
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             irq_o,
  input logic             dma_req_o,
  input logic             dma_ack_i,
  input logic [N_PIN-1:0] flag_i,
  input logic [N_PIN-1:0] ev_i,
  input logic [N_PIN-1:0] clr_i,
  input logic [N_PIN-1:0] dma_sel_i
);
  // R1
  quiet_out_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_i == '0) |-> (!irq_o && !dma_req_o));

  // R6
  dma_ack_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dma_ack_i |=> ((flag_i & $past(dma_sel_i) & ~$past(ev_i)) == '0));

  // R9
  flag_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (($past(flag_i) & ~flag_i & ~$past(clr_i)) == '0));

  // R11
  set_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (($past(ev_i) & ~flag_i) == '0));
endmodule

bind gpio_evt_port gpio_evt_chk #(.N_PIN(N_PIN)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .irq_o    (irq_o),
  .dma_req_o(dma_req_o),
  .dma_ack_i(dma_ack_i),
  .flag_i   (flag_q),
  .ev_i     (ev_v),
  .clr_i    (clr_v),
  .dma_sel_i(dma_sel)
);

// File: tb/tb_gpio_evt_port.sv
module tb_gpio_evt_port;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] ALL1 = 32'hFFFF_FFFF;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req = 1'b0, we = 1'b0, space = 1'b0, dma_ack = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0, rdata, pins = '0, pin_o, pin_oe;
  logic irq, dma;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  typedef struct { logic [31:0] exp; string tag; } item_t;
  item_t exp_q[$];

  gpio_evt_port dut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .space_i(space),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .pin_i(pins),
    .pin_o(pin_o), .pin_oe_o(pin_oe), .dma_ack_i(dma_ack),
    .irq_o(irq), .dma_req_o(dma)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // monitor: pops expected read items and compares
  always @(negedge clk) begin
    if (rst_n && req && !we) begin
      n_chk++;
      if (exp_q.size() == 0) begin
        n_fail++;
        $display("FAIL scoreboard: unexpected read, actual %h expected none", rdata);
      end else begin
        item_t it;
        it = exp_q.pop_front();
        if (rdata !== it.exp) begin
          n_fail++;
          $display("FAIL %s: actual %h expected %h", it.tag, rdata, it.exp);
        end
      end
    end
  end

  task automatic tick(); @(posedge clk); #1; endtask
  task automatic idle(int n); repeat (n) tick(); endtask

  task automatic wr(logic sp, logic [7:0] a, logic [31:0] d);
    req = 1'b1; we = 1'b1; space = sp; addr = a; wdata = d;
    tick();
    req = 1'b0; we = 1'b0;
  endtask

  task automatic rd(logic sp, logic [7:0] a, logic [31:0] e, string tag);
    item_t it;
    it.exp = e; it.tag = tag;
    exp_q.push_back(it);
    req = 1'b1; we = 1'b0; space = sp; addr = a;
    tick();
    req = 1'b0;
  endtask

  task automatic chk(logic [31:0] act, logic [31:0] e, string tag);
    n_chk++;
    if (act !== e) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, e);
    end
  endtask

  function automatic logic [31:0] md(int m); return 32'(m) << 16; endfunction
  function automatic logic [7:0] ca(int p); return 8'(p * 4); endfunction

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    tick();
    // R1 reset state
    rd(0, 8'h00, 0, "R1 dout");
    rd(0, 8'h14, 0, "R1 dir");
    rd(1, 8'hA0, 0, "R1 flags");
    rd(1, ca(5), 0, "R1 ctrl5");
    chk(irq, 0, "R1 irq"); chk(dma, 0, "R1 dma");

    // R2 data and direction
    wr(0, 8'h00, 32'hA5A5_0F0F);
    wr(0, 8'h14, 32'hFFFF_0000);
    rd(0, 8'h00, 32'hA5A5_0F0F, "R2 dout");
    rd(0, 8'h14, 32'hFFFF_0000, "R2 dir");
    chk(pin_o, 32'hA5A5_0F0F, "R2 pin_o");
    chk(pin_oe, 32'hFFFF_0000, "R2 pin_oe");

    // R3 two-flop input readback
    pins = 32'h1234_5678;
    rd(0, 8'h10, 0, "R3 cycle0");
    rd(0, 8'h10, 0, "R3 cycle1");
    rd(0, 8'h10, 32'h1234_5678, "R3 cycle2");
    pins = '0; idle(3);
    rd(1, 8'hA0, 0, "R10 off mode inert");

    // R4 rising edge, pin 3
    wr(1, ca(3), md(9));
    pins[3] = 1'b1; idle(3);
    rd(1, 8'hA0, 32'h8, "R4 rise flag");
    chk(irq, 1, "R4 irq rise");
    wr(1, 8'hA0, 32'h8);
    chk(irq, 0, "R4 irq cleared");
    pins[3] = 1'b0; idle(3);
    rd(1, 8'hA0, 0, "R4 rise ignores fall");
    // R4 falling edge, pin 5
    wr(1, ca(5), md('hA));
    pins[5] = 1'b1; idle(3);
    rd(1, 8'hA0, 0, "R4 fall ignores rise");
    pins[5] = 1'b0; idle(3);
    rd(1, 8'hA0, 32'h20, "R4 fall flag");
    wr(1, 8'hA0, ALL1);
    // R4 either edge, pin 7
    wr(1, ca(7), md('hB));
    pins[7] = 1'b1; idle(3);
    rd(1, 8'hA0, 32'h80, "R4 both rise");
    wr(1, 8'hA0, 32'h80);
    pins[7] = 1'b0; idle(3);
    rd(1, 8'hA0, 32'h80, "R4 both fall");
    wr(1, 8'hA0, ALL1);

    // R11 set wins on edge, pin 3 mode 9
    pins[3] = 1'b1; idle(3);
    pins[3] = 1'b0; idle(3);
    rd(1, 8'hA0, 32'h8, "R11 precondition");
    pins[3] = 1'b1; idle(2);
    wr(1, 8'hA0, 32'h8);
    rd(1, 8'hA0, 32'h8, "R11 set beats clear");
    wr(1, 8'hA0, 32'h8);
    rd(1, 8'hA0, 0, "R11 later clear");
    wr(1, ca(3), 0); wr(1, ca(5), 0); wr(1, ca(7), 0);
    pins[3] = 1'b0;

    // R5 level high, pin 9
    wr(1, ca(9), md('hC));
    pins[9] = 1'b1; idle(3);
    rd(1, 8'hA0, 32'h200, "R5 high flag");
    wr(1, 8'hA0, 32'h200);
    rd(1, 8'hA0, 32'h200, "R5 high persists");
    pins[9] = 1'b0; idle(3);
    wr(1, 8'hA0, 32'h200);
    rd(1, 8'hA0, 0, "R5 high released");
    wr(1, ca(9), 0);
    // R5 level low, pin 10 (already low)
    wr(1, ca(10), md(8)); idle(2);
    rd(1, 8'hA0, 32'h400, "R5 low flag");
    chk(irq, 1, "R5 low irq");
    pins[10] = 1'b1; idle(3);
    wr(1, 8'hA0, 32'h400);
    rd(1, 8'hA0, 0, "R5 low released");
    wr(1, ca(10), 0);
    pins[10] = 1'b0; idle(3);

    // R6 DMA versus interrupt
    wr(1, ca(12), md(1));
    wr(1, ca(13), md(9));
    pins[12] = 1'b1; pins[13] = 1'b1; idle(3);
    chk(dma, 1, "R6 dma req");
    rd(1, 8'hA0, 32'h3000, "R6 both flags");
    dma_ack = 1'b1; tick(); dma_ack = 1'b0;
    chk(dma, 0, "R6 ack clears dma");
    chk(irq, 1, "R6 ack keeps irq");
    rd(1, 8'hA0, 32'h2000, "R6 irq flag kept");
    wr(1, 8'hA0, ALL1);
    chk(irq, 0, "R6 irq cleared");
    wr(1, ca(14), md(2));
    pins[14] = 1'b1; idle(3);
    chk(dma, 0, "R6 dma fall ignores rise");
    pins[14] = 1'b0; idle(3);
    chk(dma, 1, "R6 dma fall");
    chk(irq, 0, "R6 dma not irq");
    dma_ack = 1'b1; tick(); dma_ack = 1'b0;
    chk(dma, 0, "R6 second ack");
    wr(1, ca(12), 0); wr(1, ca(13), 0); wr(1, ca(14), 0);
    pins[12] = 1'b0; pins[13] = 1'b0; idle(3);

    // R7 shared flag register
    wr(1, ca(4), md(9)); wr(1, ca(7), md(9));
    pins[4] = 1'b1; pins[7] = 1'b1; idle(3);
    wr(1, 8'hA0, 0);
    rd(1, 8'hA0, 32'h90, "R7 zero write no effect");
    wr(1, 8'hA0, 32'h10);
    rd(1, 8'hA0, 32'h80, "R7 single clear");
    // R8 control word readback
    rd(1, ca(7), 32'h0109_0000, "R8 ctrl flag and mode");
    // R9 mode rewrite keeps flag
    wr(1, ca(7), 0);
    rd(1, 8'hA0, 32'h80, "R9 flag kept");
    chk(irq, 0, "R9 no irq in off mode");
    rd(1, ca(7), 32'h0100_0000, "R9 ctrl readback");
    wr(1, ca(7), md(9) | 32'h0100_0000);
    rd(1, ca(7), 32'h0009_0000, "R8 ctrl clear");
    rd(1, 8'hA0, 0, "R8 flag gone");
    pins[4] = 1'b0; pins[7] = 1'b0; idle(3);
    wr(1, ca(4), 0); wr(1, ca(7), 0);
    wr(1, 8'hA0, ALL1);

    // R10 undefined codes
    wr(1, ca(20), md(5)); wr(1, ca(21), md('hF));
    pins[20] = 1'b1; pins[21] = 1'b1; idle(3);
    pins[20] = 1'b0; pins[21] = 1'b0; idle(3);
    rd(1, 8'hA0, 0, "R10 no flags");
    chk(irq, 0, "R10 irq"); chk(dma, 0, "R10 dma");
    rd(1, ca(20), 32'h0005_0000, "R10 code readback");
    // R7 all-ones clear
    wr(1, ca(0), md('hB)); wr(1, ca(31), md(3));
    pins[0] = 1'b1; pins[31] = 1'b1; idle(3);
    rd(1, 8'hA0, 32'h8000_0001, "R7 two flags");
    wr(1, 8'hA0, ALL1);
    rd(1, 8'hA0, 0, "R7 all ones clear");
    idle(2);
    finish_run();
  end
endmodule